// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block keeps the tag and replacement state of a cache without holding any data. A client presents one lookup per cycle, either a read or a write, with a byte address. The block splits that address into a block offset, a set index and a tag. It then searches every way of the selected set and answers with hit or miss and the way involved. On a miss it claims a line in the set, and the response says whether a valid line had to be thrown out to make room.

The geometry is set by three power-of-two width parameters: cache bytes, block bytes and address bits. A ways-per-set parameter selects direct mapping (1), N-way mapping (any power of two), or a single set that holds every line (-1). A policy parameter chooses how a victim is picked once the set is full: oldest fill, oldest access, fewest read hits, or pseudo-random. A flush input invalidates the whole directory in one cycle. Four saturating counters report hits, misses, evictions and flush cycles.

A request is accepted in the cycle it is presented. Its response appears on the outputs in the next cycle, and the directory state has already been updated by then, so back-to-back requests to the same block see each other's effects.

Top module: `cache_dir`

## Requirements
- R1: The lowest BLK_W address bits are the block offset and never change the outcome. The next log2(sets) bits select the set, and every bit above them forms the tag.
- R2: A request accepted in cycle t (req_valid high, flush low) raises resp_valid in cycle t+1. In that cycle resp_hit is 1 exactly when a line in the selected set is valid and holds the same tag, and resp_way gives that line's way.
- R3: On a miss, the lowest-numbered invalid way of the set is filled and resp_evict is 0. resp_evict is 1 only on a miss where every way of the set was valid, and never on a hit.
- R4: With the oldest-fill policy (encoding 0), the victim is the way filled longest ago.
- R5: With the oldest-access policy (encoding 1), the victim is the way whose last fill, read hit or write hit is oldest.
- R6: With the fewest-uses policy (encoding 2), the victim is the way with the smallest use count. A read hit adds one to the count, a write hit leaves it unchanged, and a fill sets it to zero. A tie goes to the lowest way.
- R7: With the pseudo-random policy (encoding 3, the default), the victim is a way inside the selected set, taken from a generator that advances every cycle.
- R8: Ways-per-set of 1 gives one way per set. Ways-per-set of -1 gives a single set that holds every line.
- R9: hit_count, miss_count and evict_count each add one per accepted hit, per accepted miss and per eviction. flush_count adds one for each cycle that flush is high. All four saturate at all-ones.
- R10: A cycle with flush high invalidates every line. A request presented in that same cycle is dropped: it gives no response, changes no counter and leaves no line behind.
- R11: After reset, every line is invalid, all counters read zero and resp_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_write | input | 1 | 1 for a write lookup, 0 for a read |
| req_addr | input | ADDR_W | Byte address of the lookup |
| flush | input | 1 | Invalidate all lines; has priority over a request |
| resp_valid | output | 1 | Response for the request of the previous cycle |
| resp_hit | output | 1 | Lookup hit |
| resp_way | output | WAY_IW | Way that hit or was filled |
| resp_evict | output | 1 | The fill replaced a valid line |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |
| evict_count | output | CNT_W | Saturating eviction counter |
| flush_count | output | CNT_W | Saturating count of flush cycles |

## Verification
The bench targets ties in the fewest-uses policy, write hits that must not raise a use count, and access refreshes that must reorder the oldest-access victim. A design that broke the tie toward a higher way, or that counted write hits, would evict a different way than expected, and later hits would then land in the wrong place. Requests issued together with flush are aimed at a design that lets the request through: it would raise resp_valid or leave a valid line that hits afterwards. Direct-mapped and fully associative copies run the same address stream as the four-way ones, which catches set and tag slicing that is off by one bit.

// File: rtl/cache_dir_pkg.sv
package cache_dir_pkg;

  // Replacement policy encodings
  typedef enum logic [1:0] {
    POL_FIFO = 2'd0,
    POL_LRU  = 2'd1,
    POL_LFU  = 2'd2,
    POL_RAND = 2'd3
  } repl_pol_e;

  // -1 selects a single set holding every line
  function automatic int ways_resolve(int ways_p, int lines);
    return (ways_p == -1) ? lines : ways_p;
  endfunction

  // Index width, never below one bit
  function automatic int idx_w(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cache_dir_sat_cnt.sv
module cache_dir_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && (cnt_q != '1)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/cache_dir_lfsr.sv
module cache_dir_lfsr #(
  parameter int OUT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);

  logic [15:0] st_q, st_d;

  // Galois form, polynomial x^16+x^14+x^13+x^11+1, steps every cycle
  always_comb begin
    st_d = {1'b0, st_q[15:1]};
    if (st_q[0]) st_d = st_d ^ 16'hB400;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= 16'hACE1;
    else        st_q <= st_d;
  end

  assign rnd = st_q[OUT_W-1:0];

endmodule

// File: rtl/cache_dir_pick.sv
module cache_dir_pick #(
  parameter int N  = 4,
  parameter int KW = 16,
  parameter int IW = 2
) (
  input  logic [N-1:0][KW-1:0] keys,
  output logic [IW-1:0]        idx
);

  // Smallest key wins; the strict compare keeps the lowest index on a tie
  always_comb begin
    logic [KW-1:0] best;
    best = keys[0];
    idx  = '0;
    for (int w = 1; w < N; w++) begin
      if (keys[w] < best) begin
        best = keys[w];
        idx  = IW'(w);
      end
    end
  end

endmodule

// File: rtl/cache_dir.sv
module cache_dir
  import cache_dir_pkg::*;
#(
  parameter int        CACHE_W = 6,
  parameter int        BLK_W   = 3,
  parameter int        ADDR_W  = 10,
  parameter int        WAYS    = 4,
  parameter int        TS_W    = 16,
  parameter int        CNT_W   = 16,
  parameter repl_pol_e POLICY  = POL_RAND,
  localparam int       NLINES  = 1 << (CACHE_W - BLK_W),
  localparam int       NWAYS   = ways_resolve(WAYS, NLINES),
  localparam int       WAY_IW  = idx_w(NWAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              flush,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [WAY_IW-1:0] resp_way,
  output logic              resp_evict,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  evict_count,
  output logic [CNT_W-1:0]  flush_count
);

  localparam int NSETS   = NLINES / NWAYS;
  localparam int SET_W   = (NSETS > 1) ? $clog2(NSETS) : 0;
  localparam int SET_IW  = idx_w(NSETS);
  localparam int LINE_IW = idx_w(NLINES);
  localparam int TAG_W   = ADDR_W - BLK_W - SET_W;

  // Reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  // Address fields
  logic [SET_IW-1:0] set_idx;
  logic [TAG_W-1:0]  req_tag;
  logic              offset_unused;

  generate
    if (SET_W > 0) begin : g_set
      assign set_idx = req_addr[BLK_W +: SET_W];
    end else begin : g_noset
      assign set_idx = '0;
    end
  endgenerate
  assign req_tag       = req_addr[ADDR_W-1 -: TAG_W];
  assign offset_unused = ^req_addr[BLK_W-1:0];

  // Directory state
  logic [NLINES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q  [NLINES];
  logic [TAG_W-1:0]  tag_d  [NLINES];
  logic [TS_W-1:0]   ins_q  [NLINES];
  logic [TS_W-1:0]   ins_d  [NLINES];
  logic [TS_W-1:0]   last_q [NLINES];
  logic [TS_W-1:0]   last_d [NLINES];
  logic [TS_W-1:0]   use_q  [NLINES];
  logic [TS_W-1:0]   use_d  [NLINES];
  logic [TS_W-1:0]   stamp_q, stamp_d;

  // Per-way view of the selected set
  logic [NWAYS-1:0]           hit_vec, free_vec;
  logic [NWAYS-1:0][TS_W-1:0] way_key;

  always_comb begin
    hit_vec  = '0;
    free_vec = '0;
    way_key  = '0;
    for (int w = 0; w < NWAYS; w++) begin
      logic [LINE_IW-1:0] li;
      li          = LINE_IW'(int'(set_idx) * NWAYS + w);
      hit_vec[w]  = valid_q[li] && (tag_q[li] == req_tag);
      free_vec[w] = !valid_q[li];
      case (POLICY)
        POL_FIFO: way_key[w] = ins_q[li];
        POL_LFU:  way_key[w] = use_q[li];
        default:  way_key[w] = last_q[li];
      endcase
    end
  end

  logic [WAY_IW-1:0] hit_way, free_way, min_way, rnd_way, way_sel;
  logic              hit, any_free, evict, accept;
  logic [WAY_IW-1:0] rnd_raw;

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])  hit_way  = WAY_IW'(w);
      if (free_vec[w]) free_way = WAY_IW'(w);
    end
  end

  cache_dir_pick #(.N(NWAYS), .KW(TS_W), .IW(WAY_IW)) u_pick (
    .keys (way_key),
    .idx  (min_way)
  );

  cache_dir_lfsr #(.OUT_W(WAY_IW)) u_rnd (
    .clk   (clk),
    .rst_n (rst_ok),
    .rnd   (rnd_raw)
  );

  assign rnd_way  = (NWAYS == 1) ? '0 : rnd_raw;
  assign hit      = |hit_vec;
  assign any_free = |free_vec;
  assign evict    = !hit && !any_free;
  assign accept   = req_valid && !flush;
  assign way_sel  = hit      ? hit_way  :
                    any_free ? free_way :
                    (POLICY == POL_RAND) ? rnd_way : min_way;

  logic [LINE_IW-1:0] sel_li;
  assign sel_li = LINE_IW'(int'(set_idx) * NWAYS + int'(way_sel));

  // Next state
  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    ins_d   = ins_q;
    last_d  = last_q;
    use_d   = use_q;
    stamp_d = stamp_q;
    if (flush) begin
      valid_d = '0;
    end else if (req_valid) begin
      if (stamp_q != '1) stamp_d = stamp_q + 1'b1;
      if (hit) begin
        last_d[sel_li] = stamp_q;
        if (!req_write && (use_q[sel_li] != '1)) use_d[sel_li] = use_q[sel_li] + 1'b1;
      end else begin
        valid_d[sel_li] = 1'b1;
        tag_d[sel_li]   = req_tag;
        use_d[sel_li]   = '0;
        ins_d[sel_li]   = stamp_q;
        last_d[sel_li]  = stamp_q;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      valid_q    <= '0;
      stamp_q    <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_way   <= '0;
      resp_evict <= 1'b0;
    end else begin
      valid_q    <= valid_d;
      stamp_q    <= stamp_d;
      resp_valid <= accept;
      if (accept) begin
        resp_hit   <= hit;
        resp_way   <= way_sel;
        resp_evict <= evict;
      end
    end
  end

  // Metadata is only read for valid lines, so it carries no reset
  always_ff @(posedge clk) begin
    tag_q  <= tag_d;
    ins_q  <= ins_d;
    last_q <= last_d;
    use_q  <= use_d;
  end

  // Statistics
  logic [3:0]            cnt_inc;
  logic [3:0][CNT_W-1:0] cnt_bus;

  assign cnt_inc = {flush, accept && evict, accept && !hit, accept && hit};

  generate
    for (genvar k = 0; k < 4; k++) begin : g_cnt
      cache_dir_sat_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_ok),
        .inc   (cnt_inc[k]),
        .cnt   (cnt_bus[k])
      );
    end
  endgenerate

  assign hit_count   = cnt_bus[0];
  assign miss_count  = cnt_bus[1];
  assign evict_count = cnt_bus[2];
  assign flush_count = cnt_bus[3];

endmodule

// File: rtl/cache_dir_chk.sv
module cache_dir_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             flush,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic             resp_evict,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count,
  input logic [CNT_W-1:0] flush_count
);

  p_resp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !flush) |=> resp_valid);

  p_flush_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !resp_valid);

  p_hit_no_evict_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> !resp_evict);

  p_miss_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit && ($past(miss_count) != '1)) |->
      (miss_count == $past(miss_count) + 1'b1));

  p_hit_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit && ($past(hit_count) != '1)) |->
      (hit_count == $past(hit_count) + 1'b1));

  p_flush_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && (flush_count != '1)) |=> (flush_count == $past(flush_count) + 1'b1));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> ($stable(hit_count) && $stable(miss_count)));

endmodule

bind cache_dir cache_dir_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_ok),
  .req_valid   (req_valid),
  .flush       (flush),
  .resp_valid  (resp_valid),
  .resp_hit    (resp_hit),
  .resp_evict  (resp_evict),
  .hit_count   (hit_count),
  .miss_count  (miss_count),
  .flush_count (flush_count)
);

// File: tb/sim_cache_dir.sv
module sim_cache_dir;
  import cache_dir_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NI         = 6;
  localparam int NL         = 8;

  function automatic repl_pol_e pol_of(int g);
    case (g)
      0:       return POL_FIFO;
      1:       return POL_LRU;
      2:       return POL_LFU;
      3:       return POL_RAND;
      default: return POL_LRU;
    endcase
  endfunction

  function automatic int ways_of(int g);
    return (g == 4) ? 1 : (g == 5) ? -1 : 4;
  endfunction

  function automatic int nways_of(int g);
    return (g == 4) ? 1 : (g == 5) ? 8 : 4;
  endfunction

  logic       clk, rst_n, req_valid, req_write, flush;
  logic [9:0] req_addr;

  logic        r_vld   [NI];
  logic        r_hit   [NI];
  logic        r_evict [NI];
  logic [2:0]  r_way   [NI];
  logic [15:0] c_hit   [NI];
  logic [15:0] c_miss  [NI];
  logic [15:0] c_evict [NI];
  logic [15:0] c_flush [NI];

  generate
    for (genvar g = 0; g < NI; g++) begin : g_inst
      localparam int WIW = idx_w(nways_of(g));
      logic [WIW-1:0] way_w;
      cache_dir #(.WAYS(ways_of(g)), .POLICY(pol_of(g))) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .flush       (flush),
        .resp_valid  (r_vld[g]),
        .resp_hit    (r_hit[g]),
        .resp_way    (way_w),
        .resp_evict  (r_evict[g]),
        .hit_count   (c_hit[g]),
        .miss_count  (c_miss[g]),
        .evict_count (c_evict[g]),
        .flush_count (c_flush[g])
      );
      assign r_way[g] = 3'(way_w);
    end
  endgenerate

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int total, bad;

  // Reference model
  int m_valid [NI][NL];
  int m_tag   [NI][NL];
  int m_ins   [NI][NL];
  int m_last  [NI][NL];
  int m_use   [NI][NL];
  int m_time  [NI];
  int e_hit   [NI];
  int e_miss  [NI];
  int e_evict [NI];
  int e_flush [NI];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string pol_req(int g);
    if (g >= 4) return "R8";
    case (g)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check_counts(input string req);
    for (int g = 0; g < NI; g++) begin
      chk(int'(c_hit[g])   == e_hit[g],   {req, " hits"},    int'(c_hit[g]),   e_hit[g]);
      chk(int'(c_miss[g])  == e_miss[g],  {req, " misses"},  int'(c_miss[g]),  e_miss[g]);
      chk(int'(c_evict[g]) == e_evict[g], {req, " evicts"},  int'(c_evict[g]), e_evict[g]);
      chk(int'(c_flush[g]) == e_flush[g], {req, " flushes"}, int'(c_flush[g]), e_flush[g]);
    end
  endtask

  // One lookup: drive at a falling edge, check at the next falling edge
  task automatic do_req(input bit wr, input int addr);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = 10'(addr);
    @(negedge clk);
    req_valid = 1'b0;
    for (int g = 0; g < NI; g++) begin
      int nw, ns, sb, st, tg, hw, fw, vw, li, t;
      bit eh, ev;
      string wreq;
      nw = nways_of(g);
      ns = NL / nw;
      sb = (ns > 1) ? $clog2(ns) : 0;
      st = (addr >> 3) % ns;
      tg = addr >> (3 + sb);
      t  = m_time[g];
      hw = -1;
      fw = -1;
      for (int w = nw - 1; w >= 0; w--) begin
        if (m_valid[g][st*nw+w] != 0 && m_tag[g][st*nw+w] == tg) hw = w;
        if (m_valid[g][st*nw+w] == 0) fw = w;
      end
      eh = (hw >= 0);
      ev = 1'b0;
      if (eh) begin
        vw = hw;
        wreq = (g >= 4) ? "R8" : "R2";
        li = st * nw + vw;
        m_last[g][li] = t;
        if (!wr) m_use[g][li]++;
        e_hit[g]++;
      end else begin
        e_miss[g]++;
        if (fw >= 0) begin
          vw = fw;
          wreq = (g >= 4) ? "R8" : "R3";
        end else begin
          ev = 1'b1;
          e_evict[g]++;
          wreq = pol_req(g);
          if (pol_of(g) == POL_RAND) begin
            chk(int'(r_way[g]) < nw, "R7 way range", int'(r_way[g]), nw - 1);
            vw = int'(r_way[g]) % nw;
          end else begin
            int best;
            vw = 0;
            best = 32'h7fffffff;
            for (int w = 0; w < nw; w++) begin
              int k;
              li = st * nw + w;
              k = (pol_of(g) == POL_FIFO) ? m_ins[g][li] :
                  (pol_of(g) == POL_LFU)  ? m_use[g][li] : m_last[g][li];
              if (k < best) begin
                best = k;
                vw = w;
              end
            end
          end
        end
        li = st * nw + vw;
        m_valid[g][li] = 1;
        m_tag[g][li]   = tg;
        m_use[g][li]   = 0;
        m_ins[g][li]   = t;
        m_last[g][li]  = t;
      end
      m_time[g]++;
      chk(r_vld[g] == 1'b1, "R2 resp_valid", int'(r_vld[g]), 1);
      chk(r_hit[g] == eh, (g >= 4) ? "R8 hit" : "R2 hit", int'(r_hit[g]), int'(eh));
      chk(int'(r_way[g]) == vw, wreq, int'(r_way[g]), vw);
      chk(r_evict[g] == ev, "R3 evict flag", int'(r_evict[g]), int'(ev));
    end
    check_counts("R9");
  endtask

  // Flush, optionally with a request in the same cycle that must be dropped
  task automatic do_flush(input bit with_req, input int addr);
    flush     = 1'b1;
    req_valid = with_req;
    req_write = 1'b0;
    req_addr  = 10'(addr);
    @(negedge clk);
    flush     = 1'b0;
    req_valid = 1'b0;
    for (int g = 0; g < NI; g++) begin
      for (int i = 0; i < NL; i++) m_valid[g][i] = 0;
      e_flush[g]++;
      chk(r_vld[g] == 1'b0, "R10 no response during flush", int'(r_vld[g]), 0);
    end
    check_counts("R10");
  endtask

  logic [31:0] rs;
  function automatic logic [31:0] xs(logic [31:0] v);
    logic [31:0] x;
    x = v;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad = 0;
    for (int g = 0; g < NI; g++) begin
      m_time[g] = 0;
      e_hit[g] = 0;
      e_miss[g] = 0;
      e_evict[g] = 0;
      e_flush[g] = 0;
      for (int i = 0; i < NL; i++) begin
        m_valid[g][i] = 0;
        m_tag[g][i] = 0;
        m_ins[g][i] = 0;
        m_last[g][i] = 0;
        m_use[g][i] = 0;
      end
    end
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr = '0;
    flush = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: state after reset
    for (int g = 0; g < NI; g++)
      chk(r_vld[g] == 1'b0, "R11 resp_valid after reset", int'(r_vld[g]), 0);
    check_counts("R11");

    // R1: another offset inside the same block hits
    do_req(1'b0, 10'h040);
    do_req(1'b1, 10'h047);
    for (int g = 0; g < NI; g++)
      chk(r_hit[g] == 1'b1, "R1 offset ignored", int'(r_hit[g]), 1);

    // R6: write hits must not raise the use count; read hits must
    do_req(1'b0, 10'h000);
    do_req(1'b0, 10'h020);
    do_req(1'b0, 10'h060);
    do_req(1'b1, 10'h040);
    do_req(1'b1, 10'h040);
    do_req(1'b0, 10'h020);
    do_req(1'b0, 10'h080);

    // R10: a request alongside flush leaves nothing behind
    do_flush(1'b1, 10'h100);
    do_req(1'b0, 10'h100);
    for (int g = 0; g < NI; g++)
      chk(r_hit[g] == 1'b0, "R10 dropped request not resident", int'(r_hit[g]), 0);

    // Sweeps over a wide and a narrow block range
    rs = 32'h1234_5678;
    for (int n = 0; n < 3000; n++) begin
      int nblk, blk;
      rs = xs(rs);
      nblk = (n < 1500) ? 24 : 11;
      blk = int'(rs[31:8] % 24'(nblk));
      if (n % 211 == 210) do_flush(rs[3], blk * 8);
      else do_req(rs[2] & rs[5], blk * 8 + int'(rs[7:5]));
    end

    do_flush(1'b0, 0);
    do_flush(1'b0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule